// File: doc/BRIEF.md
# Light Pen Position Latch

This block freezes the display controller's running character-address counter into a holding register when a light-pen strobe arrives. A strobe comes from one of two places: a rising edge on the external pen input, or any bus access to a dedicated "arm" port. The arm port lets software take a snapshot of where the beam is at that moment. Once the strobe is set, the held value stays put until software touches a separate "release" port, which re-arms the latch for the next capture.

Software reads the held address as two bytes, a high part and a low part, over a small I/O bus with address, read and write strobes. A status port shows whether a capture is being held. Both the pen and the arm port resolve position to the granularity of the address counter, which is one character cell across the line. The counter itself, the other controller registers and the display timing are outside this block.

Top module: `pen_pos_latch`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) the strobe flag is 0 and the held address is 0, so the high, low and status ports all read 0.
- R2: A read or a write to the arm port (address 1) while the flag is 0 sets the flag and holds the value of disp_addr sampled at the same clock edge as the access.
- R3: A read or a write to the release port (address 0) clears the flag at that clock edge. The held address keeps its value until the next capture.
- R4: While the flag is 1, further arm-port accesses and pen edges leave the held address unchanged.
- R5: pen_in passes through two synchroniser flip-flops and an edge detector. A rise of pen_in between clock edges k and k+1 captures the disp_addr value sampled at edge k+3, provided the flag is 0.
- R6: With bus_rd high, address 2 returns {2'b00, held[13:8]}, address 3 returns held[7:0], and address 4 returns {7'b0, flag}. Every other address, including the arm and release ports, returns 0, and bus_rdata is 0 whenever bus_rd is low.
- R7: When a release access and a detected pen edge fall on the same clock edge, the release wins and the flag ends up 0.
- R8: A pen input that stays high causes only one capture. After a release, a pen level held high does not set the flag again until pen_in falls and rises once more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | I/O port address |
| bus_rd | input | 1 | Read strobe; counts as an access |
| bus_wr | input | 1 | Write strobe; counts as an access, data not used |
| bus_rdata | output | 8 | Read data, combinational from address and held state |
| disp_addr | input | 14 | Live character-address counter of the display controller |
| pen_in | input | 1 | Asynchronous light-pen input, active high |

## Verification
A wrong flag shows up at the status port on the first read after the access that should have changed it. A flag left set would also make the next capture vanish, so the high and low bytes would keep their old value. A held address that shifts while the flag is set, or a capture taken one edge early or late, shows as the wrong counter value in the high and low bytes. For this reason the counter is changed on every edge around a capture. A broken edge detector shows as a capture that comes back by itself after a release while the pen is still held high.

// File: rtl/lpl_pkg.sv
// Package: shared constants of the light pen position latch.
// Assumes a 3-bit I/O port space with five decoded ports.
package lpl_pkg;
    localparam int LPL_ADDR_W = 3;
    localparam int LPL_DATA_W = 8;
    localparam logic [LPL_ADDR_W-1:0] PORT_RELEASE = 3'd0;
    localparam logic [LPL_ADDR_W-1:0] PORT_ARM     = 3'd1;
    localparam logic [LPL_ADDR_W-1:0] PORT_HIGH    = 3'd2;
    localparam logic [LPL_ADDR_W-1:0] PORT_LOW     = 3'd3;
    localparam logic [LPL_ADDR_W-1:0] PORT_STATUS  = 3'd4;
endpackage

// File: rtl/lpl_pen_sync.sv
// Module: synchronises the asynchronous pen input and emits a one-cycle
// pulse on each rising edge. Assumes STAGES >= 2.
module lpl_pen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pen_in,
    output logic pen_rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the pen level through the synchroniser and keep the prior level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pen_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign pen_rise = sync_q[STAGES-1] & ~last_q;

    // R5
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pen_rise |=> !pen_rise);
endmodule

// File: rtl/lpl_strobe_ctl.sv
// Module: strobe flag and held position register. Captures the live
// counter on the first strobe and holds it; release has priority.
module lpl_strobe_ctl #(
    parameter int POS_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_req,
    input  logic             clr_req,
    input  logic             pen_rise,
    input  logic [POS_W-1:0] disp_addr,
    output logic             flag_q,
    output logic [POS_W-1:0] pos_q
);
    logic take;
    assign take = ~flag_q & (set_req | pen_rise);

    // Update the flag and the held position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            pos_q  <= '0;
        end else if (clr_req) begin
            flag_q <= 1'b0;
        end else if (take) begin
            flag_q <= 1'b1;
            pos_q  <= disp_addr;
        end
    end

    // R2
    arm_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && set_req && !clr_req) |=> (flag_q && pos_q == $past(disp_addr)));
    // R3
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (!flag_q && $stable(pos_q)));
    // R4
    hold_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_req) |=> (flag_q && $stable(pos_q)));
    // R7
    release_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && pen_rise) |=> !flag_q);
endmodule

// File: rtl/lpl_bus_if.sv
// Module: decodes the I/O bus into arm/release requests and builds the
// read data from the held state. Write data is not used.
module lpl_bus_if
    import lpl_pkg::*;
#(
    parameter int POS_W = 14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LPL_ADDR_W-1:0] bus_addr,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic                  flag_q,
    input  logic [POS_W-1:0]      pos_q,
    output logic                  set_req,
    output logic                  clr_req,
    output logic [LPL_DATA_W-1:0] bus_rdata
);
    localparam int HI_W = POS_W - LPL_DATA_W;

    logic access;
    assign access  = bus_rd | bus_wr;
    assign set_req = access && (bus_addr == PORT_ARM);
    assign clr_req = access && (bus_addr == PORT_RELEASE);

    // Select the read byte for the addressed port.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                PORT_HIGH:   bus_rdata = {{(LPL_DATA_W-HI_W){1'b0}}, pos_q[POS_W-1:LPL_DATA_W]};
                PORT_LOW:    bus_rdata = pos_q[LPL_DATA_W-1:0];
                PORT_STATUS: bus_rdata = {{(LPL_DATA_W-1){1'b0}}, flag_q};
                default:     bus_rdata = '0;
            endcase
        end
    end

    // R6
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));
endmodule

// File: rtl/pen_pos_latch.sv
// Module: top of the light pen position latch. Joins the pen synchroniser,
// the strobe control and the bus decoder. Assumes 8 < POS_W <= 16.
module pen_pos_latch
    import lpl_pkg::*;
#(
    parameter int POS_W       = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LPL_ADDR_W-1:0] bus_addr,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    output logic [LPL_DATA_W-1:0] bus_rdata,
    input  logic [POS_W-1:0]      disp_addr,
    input  logic                  pen_in
);
    logic             pen_rise;
    logic             set_req;
    logic             clr_req;
    logic             flag_q;
    logic [POS_W-1:0] pos_q;

    lpl_pen_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pen_in(pen_in), .pen_rise(pen_rise)
    );

    lpl_strobe_ctl #(.POS_W(POS_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .set_req(set_req), .clr_req(clr_req),
        .pen_rise(pen_rise), .disp_addr(disp_addr),
        .flag_q(flag_q), .pos_q(pos_q)
    );

    lpl_bus_if #(.POS_W(POS_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .flag_q(flag_q), .pos_q(pos_q),
        .set_req(set_req), .clr_req(clr_req), .bus_rdata(bus_rdata)
    );
endmodule

// File: tb/test_pen_pos_latch.sv
// Bench: scoreboard of expected read bytes; the driver pushes, the monitor
// pops and compares on the falling edge while a read is on the bus.
module test_pen_pos_latch;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_rdata;
    logic [13:0] disp_addr = '0;
    logic        pen_in = 1'b0;

    typedef struct {
        logic [7:0] val;
        string      req;
    } exp_t;
    exp_t exp_q[$];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pen_pos_latch i_pen_pos_latch (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_rdata(bus_rdata), .disp_addr(disp_addr),
        .pen_in(pen_in)
    );

    // Monitor: compare each read against the oldest expected item.
    always @(negedge clk) begin
        if (bus_rd && !done) begin
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL scoreboard: read with no expected item, actual %02h", bus_rdata);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (bus_rdata !== e.val) begin
                    fails++;
                    $display("FAIL %s: actual %02h expected %02h", e.req, bus_rdata, e.val);
                end
            end
        end
    end

    task automatic rd_port(input logic [2:0] a, input logic [7:0] v, input string req);
        exp_t e;
        e.val = v;
        e.req = req;
        @(posedge clk); #1;
        exp_q.push_back(e);
        bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic wr_port(input logic [2:0] a);
        @(posedge clk); #1;
        bus_addr = a; bus_wr = 1'b1; bus_rd = 1'b0;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic set_disp(input logic [13:0] v);
        @(posedge clk); #1;
        disp_addr = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    // Driver: stimulus and expected values.
    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        rd_port(3'd4, 8'h00, "R1 status");
        rd_port(3'd2, 8'h00, "R1 high");
        rd_port(3'd3, 8'h00, "R1 low");

        // R2 write to arm port captures the counter
        set_disp(14'h2A5C);
        wr_port(3'd1);
        set_disp(14'h0007);
        rd_port(3'd2, 8'h2A, "R2 high");
        rd_port(3'd3, 8'h5C, "R2 low");
        rd_port(3'd4, 8'h01, "R2 status");

        // R4 later arm accesses and pen pulses do not overwrite
        set_disp(14'h1111);
        wr_port(3'd1);
        pen_in = 1'b1;
        idle(4);
        pen_in = 1'b0;
        idle(3);
        rd_port(3'd2, 8'h2A, "R4 high");
        rd_port(3'd3, 8'h5C, "R4 low");

        // R3 read of release port clears flag; held value kept
        rd_port(3'd0, 8'h00, "R6 release port reads zero");
        rd_port(3'd4, 8'h00, "R3 status");
        rd_port(3'd3, 8'h5C, "R3 held low kept");

        // R2 read access to arm port also captures
        set_disp(14'h3FFF);
        rd_port(3'd1, 8'h00, "R6 arm port reads zero");
        rd_port(3'd2, 8'h3F, "R2 read-arm high");
        rd_port(3'd3, 8'hFF, "R2 read-arm low");

        // R5 pen capture timing: value sampled at third edge after rise
        wr_port(3'd0);
        disp_addr = 14'h0222;
        pen_in = 1'b1;
        @(posedge clk); #1; disp_addr = 14'h0101;
        @(posedge clk); #1; disp_addr = 14'h0ABC;
        @(posedge clk); #1; disp_addr = 14'h0333;
        rd_port(3'd2, 8'h0A, "R5 high");
        rd_port(3'd3, 8'hBC, "R5 low");
        rd_port(3'd4, 8'h01, "R5 status");

        // R8 pen still held high: no capture after release
        wr_port(3'd0);
        idle(5);
        rd_port(3'd4, 8'h00, "R8 status");
        pen_in = 1'b0;
        idle(4);

        // R7 release coincident with the detected pen edge
        pen_in = 1'b1;
        @(posedge clk); #1;
        wr_port(3'd0);
        idle(3);
        rd_port(3'd4, 8'h00, "R7 status");
        pen_in = 1'b0;

        // R6 unmapped addresses read zero
        rd_port(3'd5, 8'h00, "R6 addr5");
        rd_port(3'd7, 8'h00, "R6 addr7");

        idle(2);
        finish_run();
    end
endmodule